// File: doc/BRIEF.md
# Link Controller Command and Status Register

This block is the primary host-visible command and status word of a frame-oriented serial link controller. The host writes it and reads it back over a plain 16-bit register port. Behind the register, the block drives handshakes toward three parties: the transmit ring engine, the receive ring engine and the link-layer state machine. It holds the transmit poll request, the stopped indication set and cleared by primitives, and the per-direction ring disable bits. It also holds the "ring on" bits, which report a disable only after the engine has finished its current frame.

When the receive side is disabled or re-enabled while a data link is established, the block issues a one-cycle request. On disable, the link layer enters local busy and sends a receiver-not-ready supervisory response. On re-enable, it sends receiver-ready. The interrupt flag positions in the word are filled from an external status vector. The logic that produces those flags lies outside this block.

Top module: `link_csr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the word reading 0x4000. Stop (bit 14) is 1 and every other bit is 0. All outputs are 0 at that point.
- R2: A host write with bit 15 = 1 sets the transmit demand (bit 15 and `tx_demand`) from the next cycle on. A write with bit 15 = 0 leaves the demand unchanged.
- R3: `tx_demand_taken` clears the transmit demand in the next cycle. If a write of bit 15 = 1 lands in the same cycle, the demand stays set.
- R4: Stop (bit 14) is set by `stop_prim` and cleared by `start_prim`, effective in the next cycle. When both arrive together, stop wins. Host writes to bit 14 are ignored.
- R5: Disable-transmit (bit 13) and disable-receive (bit 12) take the written value in the cycle after a write. They are driven out on `tx_disable` and `rx_disable`.
- R6: A `start_prim` sets transmitter-on (bit 11, `tx_ring_en`) if disable-transmit is 0, and sets receiver-on (bit 10, `rx_ring_en`) if disable-receive is 0. A direction whose disable is 1 stays off.
- R7: After its disable bit is set, an "on" bit stays 1 until that engine's one-cycle idle acknowledge (`tx_idle_ack` or `rx_idle_ack`). It then reads 0 in the next cycle. An acknowledge arriving while the disable is 0 is ignored.
- R8: A write that clears a set disable bit while stop is 0 turns the matching "on" bit on in the next cycle. While stop is 1, such a write leaves it off.
- R9: `stop_prim` clears both "on" bits in the next cycle, whatever else happens in that cycle.
- R10: Host writes to bits 11 and 10 are ignored, and bit 0 always reads 0.
- R11: A write that changes disable-receive from 0 to 1 while `link_up` is high gives a one-cycle `send_rnr` pulse in the next cycle. A change from 1 to 0 under the same condition gives `send_rr`. No pulse is produced when the link is down or when the write leaves the bit unchanged.
- R12: Bits 9 down to 1 show `irq_flags[8:0]` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Register read value |
| start_prim | input | 1 | Start primitive pulse |
| stop_prim | input | 1 | Stop primitive pulse |
| irq_flags | input | 9 | Interrupt flag bits 9..1 from outside logic |
| tx_demand_taken | input | 1 | Transmit engine has acted on the demand |
| tx_idle_ack | input | 1 | Transmit engine idle after current frame |
| rx_idle_ack | input | 1 | Receive engine idle after current frame |
| link_up | input | 1 | Data link established |
| tx_demand | output | 1 | Scan transmit ring now |
| tx_disable | output | 1 | Transmit ring disable request |
| rx_disable | output | 1 | Receive ring disable request |
| tx_ring_en | output | 1 | Transmit ring access enabled |
| rx_ring_en | output | 1 | Receive ring access enabled |
| send_rnr | output | 1 | Request receiver-not-ready response |
| send_rr | output | 1 | Request receiver-ready response |

## Verification
The bench builds the block with its default 16-bit word and 9 interrupt flag bits, which is the only shape the register takes. With this small state, a few thousand pseudo-random cycles reach every combination of disable bits, "on" bits, stop, link state and acknowledges. The cycles include simultaneous start and stop primitives, acknowledges arriving with the disable bit clear, and demand writes that collide with the engine's clear. An arithmetic model of the word is compared with every port on every cycle. Directed sequences before the sweep name the reset value, the start gating and the clear-while-stopped case.

// File: rtl/link_csr_pkg.sv
package link_csr_pkg;
  localparam int CSR_W    = 16;
  localparam int IRQ_W    = 9;
  localparam int B_DEMAND = 15;
  localparam int B_STOP   = 14;
  localparam int B_DIS_HI = 13;
  localparam int B_ON_HI  = 11;
  localparam int B_IRQ_LO = 1;
  localparam int N_DIR    = 2;
  localparam int DIR_TX   = 0;
  localparam int DIR_RX   = 1;
  localparam logic [CSR_W-1:0] RESET_WORD = CSR_W'(1) << B_STOP;
endpackage

// File: rtl/link_csr_demand.sv
module link_csr_demand (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic taken,
  output logic demand_q
);
  always_ff @(posedge clk) begin
    if (rst)          demand_q <= 1'b0;
    else if (set_req) demand_q <= 1'b1;
    else if (taken)   demand_q <= 1'b0;
  end
endmodule

// File: rtl/link_csr_ring_gate.sv
module link_csr_ring_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic stop_q,
  input  logic start_prim,
  input  logic stop_prim,
  input  logic idle_ack,
  output logic dis_q,
  output logic on_q,
  output logic dis_rise,
  output logic dis_fall
);
  logic turn_on;

  always_comb begin
    dis_rise = wr_en && wr_bit && !dis_q;
    dis_fall = wr_en && !wr_bit && dis_q;
    turn_on  = (start_prim && !dis_q) || (dis_fall && !stop_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= 1'b0;
      on_q  <= 1'b0;
    end else begin
      if (wr_en) dis_q <= wr_bit;
      if (stop_prim)              on_q <= 1'b0;
      else if (turn_on)           on_q <= 1'b1;
      else if (idle_ack && dis_q) on_q <= 1'b0;
    end
  end
endmodule

// File: rtl/link_csr_busy_sig.sv
module link_csr_busy_sig (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic rx_dis_rise,
  input  logic rx_dis_fall,
  output logic rnr_q,
  output logic rr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rnr_q <= 1'b0;
      rr_q  <= 1'b0;
    end else begin
      rnr_q <= link_up && rx_dis_rise;
      rr_q  <= link_up && rx_dis_fall;
    end
  end
endmodule

// File: rtl/link_csr.sv
module link_csr
  import link_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] rdata,
  input  logic             start_prim,
  input  logic             stop_prim,
  input  logic [IRQ_W-1:0] irq_flags,
  input  logic             tx_demand_taken,
  input  logic             tx_idle_ack,
  input  logic             rx_idle_ack,
  input  logic             link_up,
  output logic             tx_demand,
  output logic             tx_disable,
  output logic             rx_disable,
  output logic             tx_ring_en,
  output logic             rx_ring_en,
  output logic             send_rnr,
  output logic             send_rr
);
  logic             stop_q;
  logic [IRQ_W-1:0] irq_q;
  logic [N_DIR-1:0] ack_v, dis_v, on_v, rise_v, fall_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b1;
      irq_q  <= '0;
    end else begin
      if (stop_prim)       stop_q <= 1'b1;
      else if (start_prim) stop_q <= 1'b0;
      irq_q <= irq_flags;
    end
  end

  link_csr_demand u_demand (
    .clk      (clk),
    .rst      (rst),
    .set_req  (wr_en && wdata[B_DEMAND]),
    .taken    (tx_demand_taken),
    .demand_q (tx_demand)
  );

  assign ack_v[DIR_TX] = tx_idle_ack;
  assign ack_v[DIR_RX] = rx_idle_ack;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    link_csr_ring_gate u_gate (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_bit     (wdata[B_DIS_HI-d]),
      .stop_q     (stop_q),
      .start_prim (start_prim),
      .stop_prim  (stop_prim),
      .idle_ack   (ack_v[d]),
      .dis_q      (dis_v[d]),
      .on_q       (on_v[d]),
      .dis_rise   (rise_v[d]),
      .dis_fall   (fall_v[d])
    );
  end

  link_csr_busy_sig u_busy (
    .clk         (clk),
    .rst         (rst),
    .link_up     (link_up),
    .rx_dis_rise (rise_v[DIR_RX]),
    .rx_dis_fall (fall_v[DIR_RX]),
    .rnr_q       (send_rnr),
    .rr_q        (send_rr)
  );

  assign tx_disable = dis_v[DIR_TX];
  assign rx_disable = dis_v[DIR_RX];
  assign tx_ring_en = on_v[DIR_TX];
  assign rx_ring_en = on_v[DIR_RX];

  always_comb begin
    rdata = '0;
    rdata[B_DEMAND] = tx_demand;
    rdata[B_STOP]   = stop_q;
    for (int d = 0; d < N_DIR; d++) begin
      rdata[B_DIS_HI-d] = dis_v[d];
      rdata[B_ON_HI-d]  = on_v[d];
    end
    rdata[B_IRQ_LO +: IRQ_W] = irq_q;
  end
endmodule

// File: rtl/link_csr_chk.sv
module link_csr_chk
  import link_csr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CSR_W-1:0] wdata,
  input logic [CSR_W-1:0] rdata,
  input logic             start_prim,
  input logic             stop_prim,
  input logic             tx_disable,
  input logic             tx_idle_ack,
  input logic             tx_ring_en,
  input logic             tx_demand,
  input logic             send_rnr,
  input logic             send_rr
);
  p_demand_set_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && wdata[B_DEMAND] |=> tx_demand);

  p_stop_wins_r4: assert property (@(posedge clk) disable iff (rst)
    stop_prim |=> rdata[B_STOP]);

  p_on_hold_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ring_en && tx_disable && !tx_idle_ack && !stop_prim |=> tx_ring_en);

  p_stop_clears_on_r9: assert property (@(posedge clk) disable iff (rst)
    stop_prim |=> !rdata[B_ON_HI] && !rdata[B_ON_HI-1]);

  p_rnr_rr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(send_rnr && send_rr));

  p_rnr_on_rise_r11: assert property (@(posedge clk) disable iff (rst)
    send_rnr |-> rdata[B_DIS_HI-1] && !$past(rdata[B_DIS_HI-1]));

  p_rr_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
    send_rr |-> !rdata[B_DIS_HI-1] && $past(rdata[B_DIS_HI-1]));
endmodule

bind link_csr link_csr_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .rdata       (rdata),
  .start_prim  (start_prim),
  .stop_prim   (stop_prim),
  .tx_disable  (tx_disable),
  .tx_idle_ack (tx_idle_ack),
  .tx_ring_en  (tx_ring_en),
  .tx_demand   (tx_demand),
  .send_rnr    (send_rnr),
  .send_rr     (send_rr)
);

// File: tb/link_csr_test.sv
`timescale 1ns/1ps
module link_csr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        start_prim = 1'b0, stop_prim = 1'b0;
  logic [8:0]  irq_flags = '0;
  logic        tx_demand_taken = 1'b0, tx_idle_ack = 1'b0, rx_idle_ack = 1'b0;
  logic        link_up = 1'b0;
  logic        tx_demand, tx_disable, rx_disable, tx_ring_en, rx_ring_en;
  logic        send_rnr, send_rr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench model of the word
  bit m_dem, m_stop, m_dtx, m_drx, m_txon, m_rxon, m_rnr, m_rr;
  logic [8:0] m_irq;

  always #2.5 clk = ~clk;

  link_csr uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .start_prim(start_prim), .stop_prim(stop_prim), .irq_flags(irq_flags),
    .tx_demand_taken(tx_demand_taken), .tx_idle_ack(tx_idle_ack),
    .rx_idle_ack(rx_idle_ack), .link_up(link_up), .tx_demand(tx_demand),
    .tx_disable(tx_disable), .rx_disable(rx_disable), .tx_ring_en(tx_ring_en),
    .rx_ring_en(rx_ring_en), .send_rnr(send_rnr), .send_rr(send_rr));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_word();
    return {m_dem, m_stop, m_dtx, m_drx, m_txon, m_rxon, m_irq, 1'b0};
  endfunction

  // drive at negedge, advance model over the posedge, compare at next negedge
  task automatic step(bit w, logic [15:0] d, bit sta, bit stp, bit tk,
                      bit tak, bit rak, bit lk, logic [8:0] irq);
    bit txf, rxf, txs, rxs;
    wr_en = w; wdata = d; start_prim = sta; stop_prim = stp;
    tx_demand_taken = tk; tx_idle_ack = tak; rx_idle_ack = rak;
    link_up = lk; irq_flags = irq;
    txf = w && !d[13] && m_dtx;
    rxf = w && !d[12] && m_drx;
    txs = (sta && !m_dtx) || (txf && !m_stop);
    rxs = (sta && !m_drx) || (rxf && !m_stop);
    m_rnr = lk && w && d[12] && !m_drx;
    m_rr  = lk && rxf;
    if (stp) m_txon = 0; else if (txs) m_txon = 1; else if (tak && m_dtx) m_txon = 0;
    if (stp) m_rxon = 0; else if (rxs) m_rxon = 1; else if (rak && m_drx) m_rxon = 0;
    if (w && d[15]) m_dem = 1; else if (tk) m_dem = 0;
    if (stp) m_stop = 1; else if (sta) m_stop = 0;
    if (w) begin m_dtx = d[13]; m_drx = d[12]; end
    m_irq = irq;
    @(negedge clk);
    check("R2 tx_demand", {15'd0, tx_demand}, {15'd0, m_dem});
    check("R2 demand bit", {15'd0, rdata[15]}, {15'd0, m_dem});
    check("R4 stop bit", {15'd0, rdata[14]}, {15'd0, m_stop});
    check("R5 disable bits", {14'd0, rdata[13:12]}, {14'd0, m_dtx, m_drx});
    check("R5 disable outs", {14'd0, tx_disable, rx_disable}, {14'd0, m_dtx, m_drx});
    check("R7 ring enables", {14'd0, tx_ring_en, rx_ring_en}, {14'd0, m_txon, m_rxon});
    check("R12 irq bits", {7'd0, rdata[9:1]}, {7'd0, m_irq});
    check("R10 whole word", rdata, model_word());
    check("R11 rnr/rr", {14'd0, send_rnr, send_rr}, {14'd0, m_rnr, m_rr});
  endtask

  task automatic idle();
    step(0, 16'h0, 0, 0, 0, 0, 0, 0, 9'h0);
  endtask

  initial begin
    bit [31:0] s;
    m_dem = 0; m_stop = 1; m_dtx = 0; m_drx = 0; m_txon = 0; m_rxon = 0;
    m_rnr = 0; m_rr = 0; m_irq = '0;
    repeat (3) @(negedge clk);
    check("R1 reset word", rdata, 16'h4000);
    check("R1 reset outs", {9'd0, tx_demand, tx_disable, rx_disable, tx_ring_en,
          rx_ring_en, send_rnr, send_rr}, 16'h0);
    rst = 1'b0;
    // R10: writes to on bits and bit 0 ignored, R4: stop not writable
    step(1, 16'h0C01, 0, 0, 0, 0, 0, 0, 9'h0);
    check("R10 on bits ignored", rdata, 16'h4000);
    // R6: start with transmit disabled
    step(1, 16'h2000, 0, 0, 0, 0, 0, 0, 9'h0);
    step(0, 16'h0, 1, 0, 0, 0, 0, 0, 9'h0);
    check("R6 start gated", {14'd0, tx_ring_en, rx_ring_en}, 16'h0001);
    // R8: clearing disable while running turns tx on
    step(1, 16'h0000, 0, 0, 0, 0, 0, 0, 9'h0);
    check("R8 clear turns on", {15'd0, tx_ring_en}, 16'h0001);
    // R7: on stays until ack
    step(1, 16'h3000, 0, 0, 0, 0, 0, 1, 9'h0);
    check("R11 rnr pulse", {15'd0, send_rnr}, 16'h0001);
    idle();
    check("R7 on held", {14'd0, tx_ring_en, rx_ring_en}, 16'h0003);
    step(0, 16'h0, 0, 0, 0, 1, 1, 0, 9'h0);
    check("R7 on cleared by ack", {14'd0, tx_ring_en, rx_ring_en}, 16'h0000);
    // R3: demand set then taken, and collision
    step(1, 16'hB000, 0, 0, 0, 0, 0, 0, 9'h0);
    step(1, 16'hB000, 0, 0, 1, 0, 0, 0, 9'h0);
    check("R3 write beats take", {15'd0, tx_demand}, 16'h0001);
    step(0, 16'h0, 0, 0, 1, 0, 0, 0, 9'h0);
    check("R3 take clears", {15'd0, tx_demand}, 16'h0000);
    // R9 and R4: stop and start together, stop wins; then clear while stopped
    step(0, 16'h0, 1, 1, 0, 0, 0, 0, 9'h0);
    check("R4 stop wins", {15'd0, rdata[14]}, 16'h0001);
    check("R9 stop clears on", {14'd0, tx_ring_en, rx_ring_en}, 16'h0000);
    step(1, 16'h0000, 0, 0, 0, 0, 0, 1, 9'h0);
    check("R8 stopped stays off", {14'd0, tx_ring_en, rx_ring_en}, 16'h0000);
    check("R11 rr pulse", {15'd0, send_rr}, 16'h0001);
    // sweep
    s = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      step(s[0] & s[1], {s[9:6], s[5:4], 9'(s[20:12]), s[2]},
           s[23:21] == 3'b111, s[26:24] == 3'b101, s[27], s[28], s[29],
           s[30] | s[31], s[20:12]);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule